// File: doc/BRIEF.md
# Speech Data FIFO with Write-Ready Handshake

This block sits between a host processor and the frame parser of a speech synthesizer. When the synthesizer reads its speech data from the host, the host writes it one byte at a time with an active-low write strobe. Each byte goes into a circular FIFO. The block keeps three registered flags that describe the FIFO and the speech state: buffer empty, buffer low and talking. It also drives an active-low ready line. Ready goes inactive as soon as a strobe falls and returns active a fixed number of clocks later, so the host knows when its access has finished.

Speech starts on the write side of the block. When a write takes the fill level above the low mark while the block is not yet talking, the talking flag sets on that same clock edge. The block also pulses a one-cycle clear so that the parser zeroes its pending frame energy, pitch and reflection coefficients. Until that happens, the synthesis side keys off the talking flag and stays silent. The parser removes bytes through a pop request and sees the fill count. A pop on an empty FIFO is reported as an underrun. If the FIFO is full, the block parks the incoming byte and holds ready inactive until a slot frees up.

Top module: `speech_fifo_if`

## Requirements
- R1: A stored byte goes in at the tail of a circular buffer of DEPTH (16) entries. The tail pointer wraps from DEPTH-1 to 0. A pop returns bytes in write order on `pop_data`, registered one clock after the request. `count` goes up by one for each stored byte and down by one for each pop.
- R2: `buf_empty` is 1 exactly when `count` is 0. `buf_low` is 1 exactly when `count` is LOW_MARK (8) or less. Both flags are registered and change on the same edge as `count`.
- R3: A write that arrives while the FIFO holds DEPTH bytes is parked and not dropped. `rdy_n` stays 1 until a pop frees a slot. The parked byte is then stored behind the earlier bytes.
- R4: A stored byte in speak-external mode that leaves `count` above LOW_MARK while `talking` is 0 sets `talking` to 1. The same edge drives `frm_clr` high for exactly one cycle. While `buf_low` is 1 and `talking` is 0, `talking` stays 0.
- R5: `rdy_n` is 1 after the first rising clock edge that samples a falling edge on `wr_n` (1 then 0).
- R6: `rdy_n` returns to 0 exactly READY_CLKS (16) clocks after that first edge. A falling edge on `rd_n` gives the same 16-clock cycle and does not change the FIFO.
- R7: A strobe falling edge sampled while `rdy_n` is 1 is ignored. It stores no byte and does not restart the ready timer.
- R8: A pop while `count` is 0 leaves `count` and `pop_data` unchanged and pulses `underrun` high for one cycle.
- R9: A write with `spk_ext` low still runs the ready cycle but stores no byte.
- R10: `speech_done` clears `talking`. Speech then restarts only when a later write lifts `count` above LOW_MARK.
- R11: Synchronous active-high `rst` empties the FIFO and gives `count`=0, `buf_empty`=1, `buf_low`=1, `talking`=0, `frm_clr`=0 and `rdy_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spk_ext | input | 1 | 1: host writes are speech data to be buffered |
| din | input | 8 | Host write byte |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| rdy_n | output | 1 | Ready, active low |
| pop | input | 1 | Parser request to remove one byte |
| pop_data | output | 8 | Byte removed by the last successful pop |
| underrun | output | 1 | One-cycle pulse: pop on empty FIFO |
| speech_done | input | 1 | Synthesis side ended the utterance |
| count | output | 5 | Bytes held in the FIFO |
| buf_empty | output | 1 | FIFO holds no bytes |
| buf_low | output | 1 | FIFO holds LOW_MARK bytes or fewer |
| talking | output | 1 | Speech active; synthesis stays silent while 0 |
| frm_clr | output | 1 | One-cycle pulse: zero the pending frame parameters |

## Verification
The assertions check on every cycle that the count never passes the depth and that `buf_empty` always agrees with `count`. They also check that a rise of `talking` always comes with the clear pulse while the low flag is clear, that ready stays inactive while a byte is parked, and that an empty pop flags an underrun without moving the count. Only the bench scenarios can show the things that depend on history. These are the byte order across a wrap and after a parked byte, the exact 16-clock ready latency for write and read strobes, and the fact that a strobe during a busy cycle is lost. They also cover the talk restart after `speech_done` and the way a write in the other mode leaves the FIFO untouched.

// File: rtl/speech_fifo_pkg.sv
package speech_fifo_pkg;

    // Phases of the host ready handshake
    typedef enum logic [1:0] {
        RDY_IDLE = 2'd0,  // ready active, strobes accepted
        RDY_WAIT = 2'd1,  // fixed delay running
        RDY_HOLD = 2'd2   // delay done, parked byte still waiting for room
    } rdy_state_e;

endpackage

// File: rtl/sf_ready_seq.sv
module sf_ready_seq
    import speech_fifo_pkg::*;
#(
    parameter int unsigned READY_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_n,
    input  logic rd_n,
    input  logic hold,
    output logic wr_take,
    output logic rdy_n
);
    localparam int unsigned TW = $clog2(READY_CLKS + 1);
    localparam logic [TW-1:0] TLOAD = TW'(READY_CLKS - 1);

    typedef struct packed {
        rdy_state_e    st;
        logic [TW-1:0] tmr;
        logic          wr_prev;
        logic          rd_prev;
    } seq_t;

    seq_t q, d;
    logic rd_take;

    always_comb begin
        d         = q;
        d.wr_prev = wr_n;
        d.rd_prev = rd_n;
        wr_take   = q.wr_prev && !wr_n && (q.st == RDY_IDLE);
        rd_take   = q.rd_prev && !rd_n && (q.st == RDY_IDLE);
        unique case (q.st)
            RDY_IDLE: if (wr_take || rd_take) begin
                d.st  = RDY_WAIT;
                d.tmr = TLOAD;
            end
            RDY_WAIT: if (q.tmr == '0) d.st = hold ? RDY_HOLD : RDY_IDLE;
                      else             d.tmr = q.tmr - 1'b1;
            RDY_HOLD: if (!hold) d.st = RDY_IDLE;
            default:  d.st = RDY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st      <= RDY_IDLE;
            q.tmr     <= '0;
            q.wr_prev <= 1'b1;
            q.rd_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdy_n = (q.st != RDY_IDLE);

    // R5: an accepted strobe edge makes ready inactive on the next edge
    p_ready_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (q.wr_prev && !wr_n && !rdy_n) |=> rdy_n);
    // R6: ready is never released while the delay still runs
    p_no_early_release_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == RDY_WAIT && q.tmr != '0) |=> rdy_n);
endmodule

// File: rtl/sf_byte_ring.sv
module sf_byte_ring #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                pop_data,
    output logic                         underrun,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic [$clog2(DEPTH+1)-1:0]   count_nx,
    output logic                         full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [CW-1:0] cnt;
        logic [DW-1:0] pdata;
        logic          unr;
    } ring_t;

    ring_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        d.unr   = 1'b0;
        do_push = push && (q.cnt != DEPTH_C);
        do_pop  = pop && (q.cnt != '0);
        if (do_push) d.tail = step(q.tail);
        if (do_pop) begin
            d.head  = step(q.head);
            d.pdata = mem[q.head];
        end
        if (pop && (q.cnt == '0)) d.unr = 1'b1;
        unique case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.tail] <= push_data;
    end

    assign pop_data = q.pdata;
    assign underrun = q.unr;
    assign count    = q.cnt;
    assign count_nx = d.cnt;
    assign full     = (q.cnt == DEPTH_C);

    // R3: the fill level never passes the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= DEPTH_C);
    // R8: an empty pop flags underrun and leaves the count alone
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && q.cnt == '0) |=> (q.unr && $stable(q.cnt)));
endmodule

// File: rtl/speech_fifo_if.sv
module speech_fifo_if #(
    parameter int unsigned DW         = 8,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned LOW_MARK   = 8,
    parameter int unsigned READY_CLKS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spk_ext,
    input  logic [DW-1:0]               din,
    input  logic                        wr_n,
    input  logic                        rd_n,
    output logic                        rdy_n,
    input  logic                        pop,
    output logic [DW-1:0]               pop_data,
    output logic                        underrun,
    input  logic                        speech_done,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        buf_empty,
    output logic                        buf_low,
    output logic                        talking,
    output logic                        frm_clr
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LOW_C = CW'(LOW_MARK);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] pbyte;
        logic          empty;
        logic          low;
        logic          talk;
        logic          clr;
    } top_t;

    top_t q, d;

    logic          wr_take, full, push;
    logic [DW-1:0] push_byte;
    logic [CW-1:0] count_nx;

    sf_ready_seq #(.READY_CLKS(READY_CLKS)) u_rdy (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .hold    (q.pend),
        .wr_take (wr_take),
        .rdy_n   (rdy_n)
    );

    sf_byte_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_byte),
        .pop       (pop),
        .pop_data  (pop_data),
        .underrun  (underrun),
        .count     (count),
        .count_nx  (count_nx),
        .full      (full)
    );

    always_comb begin
        d         = q;
        push      = 1'b0;
        push_byte = din;
        if (q.pend) begin
            if (!full) begin
                push      = 1'b1;
                push_byte = q.pbyte;
                d.pend    = 1'b0;
            end
        end else if (wr_take && spk_ext) begin
            if (!full) push = 1'b1;
            else begin
                d.pend  = 1'b1;
                d.pbyte = din;
            end
        end
        d.empty = (count_nx == '0);
        d.low   = (count_nx <= LOW_C);
        d.clr   = 1'b0;
        if (speech_done) d.talk = 1'b0;
        if (push && spk_ext && !q.talk && (count_nx > LOW_C)) begin
            d.talk = 1'b1;
            d.clr  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.pend  <= 1'b0;
            q.pbyte <= '0;
            q.empty <= 1'b1;
            q.low   <= 1'b1;
            q.talk  <= 1'b0;
            q.clr   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign buf_empty = q.empty;
    assign buf_low   = q.low;
    assign talking   = q.talk;
    assign frm_clr   = q.clr;

    // R2: the registered empty flag tracks the ring's count
    p_empty_flag_r2: assert property (@(posedge clk) disable iff (rst)
        q.empty == (count == '0));
    // R4: talking only rises together with the clear pulse, above the low mark
    p_talk_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(q.talk) |-> (q.clr && !q.low));
    // R3: a parked byte keeps ready inactive
    p_pend_holds_r3: assert property (@(posedge clk) disable iff (rst)
        q.pend |-> rdy_n);
endmodule

// File: tb/sim_speech_fifo_if.sv
`timescale 1ns/1ps
module sim_speech_fifo_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spk_ext = 1'b1;
    logic [7:0] din = 8'h00;
    logic       wr_n = 1'b1, rd_n = 1'b1, pop = 1'b0, speech_done = 1'b0;
    logic       rdy_n, underrun, buf_empty, buf_low, talking, frm_clr;
    logic [7:0] pop_data;
    logic [4:0] count;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    speech_fifo_if u0 (
        .clk(clk), .rst(rst), .spk_ext(spk_ext), .din(din), .wr_n(wr_n),
        .rd_n(rd_n), .rdy_n(rdy_n), .pop(pop), .pop_data(pop_data),
        .underrun(underrun), .speech_done(speech_done), .count(count),
        .buf_empty(buf_empty), .buf_low(buf_low), .talking(talking),
        .frm_clr(frm_clr)
    );

    // vector: [19:18] op (0 write, 1 pop, 2 done) [17:10] byte
    //         [9:5] count [4] empty [3] low [2] talking [1] clear pulse
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 8'h10, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h11, 5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h12, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h13, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h14, 5'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h15, 5'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h16, 5'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h17, 5'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h18, 5'd9, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd1, 8'h10, 5'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd1, 8'h11, 5'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {2'd2, 8'h00, 5'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h19, 5'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd0, 8'h1A, 5'd9, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // strobe a byte in; report the clear pulse, first ready value and latency
    task automatic do_strobe(input logic is_rd, input logic [7:0] b,
                             output logic clr, output logic rdy0, output int lat);
        @(negedge clk);
        din = b;
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1;
        clr = frm_clr; rdy0 = rdy_n; lat = 0;
        while (rdy_n && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic clr, rdy0;
        int   lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 rdy_n", rdy_n, 0);
        chk("R11 count", count, 0);
        chk("R11 empty", buf_empty, 1);
        chk("R11 low", buf_low, 1);
        chk("R11 talking", talking, 0);

        // vector walk: R1 R2 R4 R6 R10
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            clr = 1'b0;
            unique case (v[19:18])
                2'd0: begin
                    do_strobe(1'b0, v[17:10], clr, rdy0, lat);
                    chk("R5 ready drop", rdy0, 1);
                    chk("R6 ready latency", lat, 16);
                    chk("R4 clear pulse", clr, v[1]);
                end
                2'd1: begin
                    do_pop();
                    chk("R1 pop order", pop_data, v[17:10]);
                end
                default: begin
                    @(negedge clk); speech_done = 1'b1;
                    @(negedge clk); speech_done = 1'b0;
                end
            endcase
            chk("R1 count", count, v[9:5]);
            chk("R2 empty", buf_empty, v[4]);
            chk("R2 low", buf_low, v[3]);
            chk("R10 talking", talking, v[2]);
        end

        // R8 empty pop
        do_reset();
        do_pop();
        chk("R8 underrun", underrun, 1);
        chk("R8 count", count, 0);
        chk("R8 pop_data unchanged", pop_data, 0);
        @(negedge clk);
        chk("R8 underrun one cycle", underrun, 0);

        // R9 other mode: ready cycle runs, nothing stored
        spk_ext = 1'b0;
        do_strobe(1'b0, 8'h77, clr, rdy0, lat);
        chk("R9 latency", lat, 16);
        chk("R9 count", count, 0);
        spk_ext = 1'b1;

        // R6 read strobe
        do_strobe(1'b1, 8'h00, clr, rdy0, lat);
        chk("R6 read ready drop", rdy0, 1);
        chk("R6 read latency", lat, 16);
        chk("R6 read no store", count, 0);

        // R7 strobe during busy ignored
        @(negedge clk); din = 8'h55; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        din = 8'h66; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; lat++;
        while (rdy_n && lat < 200) begin @(negedge clk); lat++; end
        chk("R7 timer not restarted", lat, 16);
        chk("R7 one byte stored", count, 1);
        do_pop();
        chk("R7 first byte kept", pop_data, 8'h55);

        // R3 full FIFO parks the byte
        do_reset();
        for (int k = 0; k < 16; k++) do_strobe(1'b0, 8'hA0 + 8'(k), clr, rdy0, lat);
        chk("R3 full count", count, 16);
        @(negedge clk); din = 8'hEE; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (30) @(negedge clk);
        chk("R3 ready held", rdy_n, 1);
        chk("R3 count held", count, 16);
        do_pop();
        chk("R3 first out", pop_data, 8'hA0);
        lat = 0;
        while (rdy_n && lat < 20) begin @(negedge clk); lat++; end
        chk("R3 ready released", rdy_n, 0);
        chk("R3 parked byte stored", count, 16);
        for (int k = 1; k < 16; k++) begin
            do_pop();
            chk("R1 wrap order", pop_data, 8'hA0 + 8'(k));
        end
        do_pop();
        chk("R3 parked byte last", pop_data, 8'hEE);
        chk("R2 empty after drain", buf_empty, 1);

        summary();
        $finish;
    end
endmodule